// File: doc/BRIEF.md
# Segmented Pipelined Time-Base Counter

This block is a wide, free-running binary counter meant to run at a high clock rate. Used as a time base, each count stands for one clock period: at 400 MHz one step is 2.5 ns. The counter is split into narrow segments. Each segment keeps a registered "all ones" flag. The flag is raised one increment early, on the step that moves the segment to its all-ones value. A higher segment advances when the enable is active and every lower segment's flag is set. No carry has to ripple through the full width in a single cycle, so the longest adder path is one segment wide.

The count enable may come straight from a device pin, so it passes through a two-flop synchroniser before it gates counting. The block also produces a valid flag and a one-cycle wrap pulse. The valid flag is high when the count value was advanced at the previous edge. The wrap pulse marks the cycle in which the count has just gone from all ones to zero. An active-high synchronous reset clears everything at once.

Top module: `seg_timebase`

## Requirements
- R1: `count_o` is `SEG_W*NUM_SEGS` bits wide and is built from `NUM_SEGS` segments of `SEG_W` bits each. The defaults are 3 segments of 8 bits, giving 24 bits. The count wraps to zero after exactly 2^(SEG_W*NUM_SEGS) increments.
- R2: When `rst_i` is sampled high at an edge, after that edge `count_o` is zero, `cnt_vld_o` and `wrap_o` are low, every segment flag is clear and the synchroniser is clear. This holds whatever the other inputs are.
- R3: Start latency. If `cnt_en_i` is first sampled high at edge k, the first increment of `count_o` happens at edge k+2.
- R4: Stop latency. If `cnt_en_i` is first sampled low at edge k after being high, increments still happen at edges k and k+1, and none happens at edge k+2.
- R5: While the synchronised enable is high, `count_o` rises by exactly one per clock, modulo 2^(SEG_W*NUM_SEGS). One step equals one clock period (2.5 ns at 400 MHz).
- R6: While the synchronised enable is low, `count_o` holds its value.
- R7: `count_o` matches a plain binary counter on every cycle, including every segment rollover. A higher segment advances on the same edge at which the segments below it wrap.
- R8: Pausing the enable while a segment holds all-ones-minus-one or all-ones, then resuming, leaves the count exact. The internal flag of each segment is high exactly when that segment holds all ones.
- R9: `wrap_o` is high for exactly one cycle: the cycle after the edge at which `count_o` went from all ones to zero. It is low at all other times.
- R10: `cnt_vld_o` is high exactly in those cycles in which `count_o` was incremented at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Count enable, may be asynchronous to `clk_i` |
| count_o | output | SEG_W*NUM_SEGS | Registered count value |
| cnt_vld_o | output | 1 | High when `count_o` advanced at the last edge |
| wrap_o | output | 1 | One-cycle pulse after the wrap from all ones to zero |

## Verification
The bench runs a narrower instance (three 4-bit segments), so that every segment boundary and a full wrap occur within a short run. It checks the outputs against a plain reference counter on every cycle. If the early flag were set on the wrong value, or left stale, the upper segments would advance one count early or late at each rollover. This fault shows up as a count error at values such as 0x0F→0x10 and 0xFF→0x100. The bench pauses the enable exactly at all-ones-minus-one and at all-ones in each segment. A flag updated without regard to the enable would fire during the pause and corrupt the count on resume. Exact start and stop latencies catch a synchroniser with one stage too few or too many. A stuck or misplaced wrap pulse fails the one-pulse-per-4096-steps check.

// File: rtl/seg_timebase_pkg.sv
package seg_timebase_pkg;
  parameter int unsigned DEF_SEG_W    = 8;
  parameter int unsigned DEF_NUM_SEGS = 3;
  parameter int unsigned DEF_SYNC     = 2;
endpackage

// File: rtl/segtb_sync.sv
module segtb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/segtb_slice.sv
module segtb_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  output logic [W-1:0] val_o,
  output logic         full_o
);
  localparam logic [W-1:0] NEAR_TOP = {{(W-1){1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      val_o  <= '0;
      full_o <= 1'b0;
    end else if (step_i) begin
      val_o  <= val_o + 1'b1;
      // flag rises on the step into all-ones, drops on the step out of it
      full_o <= (val_o == NEAR_TOP);
    end
  end
endmodule

// File: rtl/seg_timebase.sv
module seg_timebase
  import seg_timebase_pkg::*;
#(
  parameter int unsigned SEG_W       = DEF_SEG_W,
  parameter int unsigned NUM_SEGS    = DEF_NUM_SEGS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  localparam int unsigned CNT_W      = SEG_W * NUM_SEGS
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cnt_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cnt_vld_o,
  output logic             wrap_o
);
  logic                en_s;
  logic [NUM_SEGS-1:0] seg_step;
  logic [NUM_SEGS-1:0] seg_full;
  logic [CNT_W-1:0]    cnt_w;

  segtb_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk_i),
    .rst (rst_i),
    .d_i (cnt_en_i),
    .q_o (en_s)
  );

  assign seg_step[0] = en_s;

  generate
    for (genvar g = 1; g < NUM_SEGS; g++) begin : g_step
      assign seg_step[g] = seg_step[g-1] & seg_full[g-1];
    end
    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
      segtb_slice #(.W(SEG_W)) slice_i (
        .clk    (clk_i),
        .rst    (rst_i),
        .step_i (seg_step[g]),
        .val_o  (cnt_w[g*SEG_W +: SEG_W]),
        .full_o (seg_full[g])
      );
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_vld_o <= 1'b0;
      wrap_o    <= 1'b0;
    end else begin
      cnt_vld_o <= en_s;
      wrap_o    <= en_s & (&seg_full);
    end
  end

  assign count_o = cnt_w;
endmodule

// File: rtl/seg_timebase_chk.sv
module seg_timebase_chk #(
  parameter int unsigned SEG_W    = 8,
  parameter int unsigned NUM_SEGS = 3,
  localparam int unsigned CNT_W   = SEG_W * NUM_SEGS
) (
  input logic                clk,
  input logic                rst,
  input logic                en_pin,
  input logic [CNT_W-1:0]    count,
  input logic                vld,
  input logic                wrap,
  input logic [NUM_SEGS-1:0] seg_full
);
  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (count == '0 && !vld && !wrap && seg_full == '0)); // R2

  AST_EN_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3)) |-> (vld == $past(en_pin, 3))); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    vld |-> (count == CNT_W'($past(count) + 1'b1))); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!vld && !$past(rst)) |-> (count == $past(count))); // R6

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (count == '0 && vld)); // R9

  AST_WRAP_SEEN: assert property (@(posedge clk) disable iff (rst)
    (vld && count == '0) |-> wrap); // R9

  generate
    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_align
      AST_CARRY_ALIGN: assert property (@(posedge clk) disable iff (rst)
        seg_full[g] == (&count[g*SEG_W +: SEG_W])); // R8
    end
  endgenerate
endmodule

bind seg_timebase seg_timebase_chk #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS)) chk_i (
  .clk      (clk_i),
  .rst      (rst_i),
  .en_pin   (cnt_en_i),
  .count    (count_o),
  .vld      (cnt_vld_o),
  .wrap     (wrap_o),
  .seg_full (seg_full)
);

// File: tb/seg_timebase_tb_top.sv
module seg_timebase_tb_top;
  localparam int unsigned SEG_W    = 4;
  localparam int unsigned NUM_SEGS = 3;
  localparam int unsigned W        = SEG_W * NUM_SEGS;
  localparam logic [W-1:0] MAXV    = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] count;
  logic         vld, wrap;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [W-1:0] exp_cnt = '0;
  logic         exp_vld = 1'b0, exp_tc = 1'b0, sh1 = 1'b0, sh2 = 1'b0;
  int           tc_seen = 0;

  always #5 clk = ~clk;

  seg_timebase #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .SYNC_STAGES(2)) dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .cnt_en_i  (en),
    .count_o   (count),
    .cnt_vld_o (vld),
    .wrap_o    (wrap)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive enable, advance the reference model, compare at negedge
  task automatic step(input logic v, input string tag);
    en = v;
    @(posedge clk);
    if (rst) begin
      exp_cnt = '0; exp_vld = 0; exp_tc = 0; sh1 = 0; sh2 = 0;
    end else begin
      exp_tc  = sh2 && (exp_cnt == MAXV);
      exp_vld = sh2;
      if (sh2) exp_cnt = exp_cnt + 1'b1;
      sh2 = sh1;
      sh1 = v;
    end
    @(negedge clk);
    chk(tag, "count", int'(count), int'(exp_cnt));
    chk("R9", "wrap", int'(wrap), int'(exp_tc));
    chk("R10", "valid", int'(vld), int'(exp_vld));
    if (wrap) tc_seen++;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, "R2");
    chk("R2", "count after reset", int'(count), 0);
    rst = 1'b0;
  endtask

  task automatic t_start();
    for (int i = 0; i < 4; i++) step(1'b0, "R6");
    chk("R6", "idle count", int'(count), 0);
    step(1'b1, "R3");
    chk("R3", "edge k", int'(count), 0);
    step(1'b1, "R3");
    chk("R3", "edge k+1", int'(count), 0);
    step(1'b1, "R3");
    chk("R3", "edge k+2", int'(count), 1);
  endtask

  task automatic t_stop();
    int base;
    for (int i = 0; i < 20; i++) step(1'b1, "R5");
    base = int'(count);
    step(1'b0, "R4");
    step(1'b0, "R4");
    chk("R4", "two trailing steps", int'(count), base + 2);
    for (int i = 0; i < 6; i++) step(1'b0, "R6");
    chk("R6", "held while off", int'(count), base + 2);
  endtask

  task automatic t_full_run();
    t_reset();
    tc_seen = 0;
    for (int i = 0; i < 4096 + 10; i++) step(1'b1, "R5/R7");
    chk("R9", "wrap pulses in one period", tc_seen, 1);
    chk("R1", "value after 4096+8 steps", int'(count), 8);
  endtask

  task automatic t_pause_at(input logic [W-1:0] target);
    while (exp_cnt != W'(target - 2)) step(1'b1, "R7");
    for (int i = 0; i < 8; i++) step(1'b0, "R8");
    chk("R8", "paused value", int'(count), int'(target));
    for (int i = 0; i < 6; i++) step(1'b1, "R8");
  endtask

  task automatic t_boundaries();
    t_reset();
    for (int i = 0; i < 2; i++) step(1'b1, "R7");
    t_pause_at(W'(14));
    t_pause_at(W'(15));
    t_pause_at(W'(254));
    t_pause_at(W'(255));
    t_pause_at(W'(4094));
    t_pause_at(W'(4095));
    for (int i = 0; i < 10; i++) step(1'b1, "R7");
  endtask

  task automatic t_reset_midrun();
    for (int i = 0; i < 30; i++) step(1'b1, "R5");
    rst = 1'b1;
    step(1'b1, "R2");
    chk("R2", "mid-run reset", int'(count), 0);
    chk("R2", "valid after reset", int'(vld), 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) step(1'b1, "R3");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_start();
    t_stop();
    t_full_run();
    t_boundaries();
    t_reset_midrun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule